// File: doc/BRIEF.md
# Register-File Burst Transfer Sequencer

This block is a multi-cycle sequencer for the two block-transfer instructions of a small load/store processor. One instruction copies registers 1 to REG_CNT-1 into consecutive memory words. The other fills those registers from consecutive memory words. The decoder supplies three things: a one-cycle start pulse, a direction bit, and a byte base address. The base address is already the sum of a register value and the sign-extended immediate. The sequencer then drives the register-file port and the memory port itself, moving one register per clock. While it runs it holds a busy flag that the pipeline uses as a stall. When the burst completes it raises a one-cycle done pulse.

Register i is paired with byte address base + 4*i. The memory is word addressed, so the block converts this to the word index ((base >> 2) + i) mod MEM_WORDS. The register file gives read data in the same cycle as its address. The memory gives read data one cycle after its address. As a result, a load writes each register one cycle after that register's memory word was addressed.

The controller has six states:
- `S_IDLE`: waits for a start pulse.
- `S_ST_XFER`: performs one store per cycle.
- `S_LD_FIRST`: issues only the first load address.
- `S_LD_STREAM`: issues the next load address while writing the register for the previous one.
- `S_LD_LAST`: writes the final register only.
- `S_FINISH`: drives the done pulse.

The transitions are:
- A start with direction 1 moves IDLE to ST_XFER.
- A start with direction 0 moves IDLE to LD_FIRST.
- ST_XFER moves to FINISH after index REG_CNT-1.
- LD_FIRST moves to LD_STREAM, or to LD_LAST when the register count is 2.
- LD_STREAM moves to LD_LAST after issuing index REG_CNT-1.
- LD_LAST moves to FINISH.
- FINISH moves to IDLE.

Top module: `rf_burst_seq`

## Requirements
- R1: In `S_IDLE`, a start pulse with `dir_store_i`=1 stores register i into memory word ((base>>2)+i) mod MEM_WORDS, for every i from 1 to REG_CNT-1. Each write uses the register data read at index i in the same cycle.
- R2: In `S_IDLE`, a start pulse with `dir_store_i`=0 writes memory word ((base>>2)+i) mod MEM_WORDS into register i, for every i from 1 to REG_CNT-1. The register write for index i comes one cycle after that word's address is driven.
- R3: Register 0 is never transferred. No register write targets index 0, so a load leaves register 0 unchanged. A store touches no memory word other than the REG_CNT-1 words in its window.
- R4: Bits [1:0] of the base address, and all bits above bit MIDX_W+1, have no effect on the word index. The word index wraps modulo MEM_WORDS. MEM_WORDS must be a power of two.
- R5: One register moves per clock. A store has REG_CNT-1 busy cycles, each with one memory write. A load has REG_CNT busy cycles with REG_CNT-1 register writes. Consecutive writes step the index by exactly one.
- R6: `busy_o` rises in the cycle after an accepted start. It then stays high without a gap until the last transfer cycle.
- R7: `done_o` is high for exactly one cycle, the cycle right after busy falls. `busy_o` is low in that cycle.
- R8: A start pulse that arrives while `busy_o` or `done_o` is high is ignored. The running burst keeps its direction, base and length, and no new burst follows.
- R9: `rf_we_o` and `mem_we_o` are never high together, and neither is high outside busy cycles. A store never writes a register and a load never writes memory.
- R10: While reset is asserted and right after it, the block is in `S_IDLE` with `busy_o`, `done_o`, `rf_we_o` and `mem_we_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a burst |
| dir_store_i | input | 1 | 1 = registers to memory, 0 = memory to registers |
| base_addr_i | input | ADDR_W | Byte base address (register plus sign-extended immediate) |
| rf_addr_o | output | RIDX_W | Register-file index for the read or write |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | DATA_W | Register-file write data (memory read data) |
| rf_rdata_i | input | DATA_W | Register-file read data for `rf_addr_o`, same cycle |
| mem_addr_o | output | MIDX_W | Memory word index |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data (register read data) |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after its address |
| busy_o | output | 1 | Burst in progress; stalls the pipeline |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with REG_CNT=8 and MEM_WORDS=16. With these values a burst is eight cycles, so every one of the sixteen starting word positions can be run in both directions. A seven-register window that starts near the top of a sixteen-word memory wraps around to word 0. This makes the modulo addressing and the untouched words on both sides of the window easy to check. Garbage in the low two bits and the high bits of the base confirms that those bits are ignored. Ignored start pulses are placed both in the middle of a burst and on the done cycle.

// File: rtl/rf_burst_pkg.sv
package rf_burst_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_ST_XFER   = 3'd1,
        S_LD_FIRST  = 3'd2,
        S_LD_STREAM = 3'd3,
        S_LD_LAST   = 3'd4,
        S_FINISH    = 3'd5
    } burst_state_t;

    typedef struct packed {
        logic idx_load;
        logic idx_adv;
        logic base_cap;
        logic use_lag;
        logic rf_we;
        logic mem_we;
        logic busy;
        logic done;
    } burst_ctl_t;

endpackage

// File: rtl/rf_burst_idx.sv
// Register index counter with a one-cycle-delayed copy for load write-back.
module rf_burst_idx #(
    parameter int RIDX_W   = 5,
    parameter int LAST_IDX = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [RIDX_W-1:0] idx_o,
    output logic [RIDX_W-1:0] lag_o,
    output logic              last_o
);

    localparam logic [RIDX_W-1:0] FIRST = RIDX_W'(1);
    localparam logic [RIDX_W-1:0] LAST  = RIDX_W'(LAST_IDX);

    logic [RIDX_W-1:0] idx_q;
    logic [RIDX_W-1:0] lag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            lag_q <= '0;
        end else if (load_i) begin
            idx_q <= FIRST;
            lag_q <= '0;
        end else if (adv_i) begin
            idx_q <= idx_q + FIRST;
            lag_q <= idx_q;
        end
    end

    assign idx_o  = idx_q;
    assign lag_o  = lag_q;
    assign last_o = (idx_q == LAST);

endmodule

// File: rtl/rf_burst_addr.sv
// Captures the base word index and adds the register index modulo memory size.
module rf_burst_addr #(
    parameter int ADDR_W = 32,
    parameter int MIDX_W = 11,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [MIDX_W-1:0] base_word_i,
    input  logic [RIDX_W-1:0] idx_i,
    output logic [MIDX_W-1:0] word_o
);

    localparam int SUM_W = ((MIDX_W > RIDX_W) ? MIDX_W : RIDX_W) + 1;

    logic [MIDX_W-1:0] base_q;
    logic [SUM_W-1:0]  sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (cap_i) begin
            base_q <= base_word_i;
        end
    end

    assign sum    = SUM_W'(base_q) + SUM_W'(idx_i);
    assign word_o = sum[MIDX_W-1:0];

    if (ADDR_W < MIDX_W + 2) begin : g_bad_width
        initial $error("rf_burst_addr: ADDR_W too small for MIDX_W");
    end

endmodule

// File: rtl/rf_burst_fsm.sv
// Burst controller: state register, next-state logic, output decode.
module rf_burst_fsm
    import rf_burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         dir_store_i,
    input  logic         last_i,
    output burst_state_t state_o,
    output burst_ctl_t   ctl_o
);

    burst_state_t state_q;
    burst_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = dir_store_i ? S_ST_XFER : S_LD_FIRST;
                end
            end
            S_ST_XFER: begin
                if (last_i) begin
                    state_d = S_FINISH;
                end
            end
            S_LD_FIRST: begin
                state_d = last_i ? S_LD_LAST : S_LD_STREAM;
            end
            S_LD_STREAM: begin
                if (last_i) begin
                    state_d = S_LD_LAST;
                end
            end
            S_LD_LAST: begin
                state_d = S_FINISH;
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            S_IDLE: begin
                ctl_o.idx_load = start_i;
                ctl_o.base_cap = start_i;
            end
            S_ST_XFER: begin
                ctl_o.busy    = 1'b1;
                ctl_o.mem_we  = 1'b1;
                ctl_o.idx_adv = 1'b1;
            end
            S_LD_FIRST: begin
                ctl_o.busy    = 1'b1;
                ctl_o.idx_adv = 1'b1;
            end
            S_LD_STREAM: begin
                ctl_o.busy    = 1'b1;
                ctl_o.rf_we   = 1'b1;
                ctl_o.use_lag = 1'b1;
                ctl_o.idx_adv = 1'b1;
            end
            S_LD_LAST: begin
                ctl_o.busy    = 1'b1;
                ctl_o.rf_we   = 1'b1;
                ctl_o.use_lag = 1'b1;
            end
            S_FINISH: begin
                ctl_o.done = 1'b1;
            end
            default: begin
                ctl_o = '0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/rf_burst_seq.sv
// Top: sequences a register-file <-> memory block transfer.
module rf_burst_seq
    import rf_burst_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int ADDR_W    = 32,
    parameter  int REG_CNT   = 32,
    parameter  int MEM_WORDS = 2048,
    localparam int RIDX_W    = $clog2(REG_CNT),
    localparam int MIDX_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_store_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic [RIDX_W-1:0] rf_addr_o,
    output logic              rf_we_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic [MIDX_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o
);

    localparam int LAST_IDX = REG_CNT - 1;

    burst_state_t      state;
    burst_ctl_t        ctl;
    logic [RIDX_W-1:0] idx;
    logic [RIDX_W-1:0] lag;
    logic              last;
    logic [MIDX_W-1:0] word;
    logic [MIDX_W-1:0] base_word;
    logic              unused_base_bits;
    logic              unused_state;

    assign base_word        = base_addr_i[MIDX_W+1:2];
    assign unused_base_bits = ^{base_addr_i[ADDR_W-1:MIDX_W+2], base_addr_i[1:0]};
    assign unused_state     = ^state;

    rf_burst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dir_store_i (dir_store_i),
        .last_i      (last),
        .state_o     (state),
        .ctl_o       (ctl)
    );

    rf_burst_idx #(
        .RIDX_W   (RIDX_W),
        .LAST_IDX (LAST_IDX)
    ) u_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ctl.idx_load),
        .adv_i  (ctl.idx_adv),
        .idx_o  (idx),
        .lag_o  (lag),
        .last_o (last)
    );

    rf_burst_addr #(
        .ADDR_W (ADDR_W),
        .MIDX_W (MIDX_W),
        .RIDX_W (RIDX_W)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (ctl.base_cap),
        .base_word_i (base_word),
        .idx_i       (idx),
        .word_o      (word)
    );

    assign rf_addr_o   = ctl.use_lag ? lag : idx;
    assign rf_we_o     = ctl.rf_we;
    assign rf_wdata_o  = mem_rdata_i;
    assign mem_addr_o  = word;
    assign mem_we_o    = ctl.mem_we;
    assign mem_wdata_o = rf_rdata_i;
    assign busy_o      = ctl.busy;
    assign done_o      = ctl.done;

endmodule

// File: rtl/rf_burst_seq_chk.sv
// Protocol checker, bound into rf_burst_seq.
module rf_burst_seq_chk #(
    parameter int RIDX_W = 5,
    parameter int MIDX_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              rf_we_o,
    input logic [RIDX_W-1:0] rf_addr_o,
    input logic              mem_we_o,
    input logic [MIDX_W-1:0] mem_addr_o
);

    p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_follows_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && !busy_o));

    p_no_reg0_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (rf_addr_o != '0));

    p_we_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we_o && mem_we_o));

    p_we_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o || mem_we_o) |-> busy_o);

    p_mem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == MIDX_W'($past(mem_addr_o) + 1'b1)));

    p_rf_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && $past(rf_we_o)) |-> (rf_addr_o == RIDX_W'($past(rf_addr_o) + 1'b1)));

endmodule

bind rf_burst_seq rf_burst_seq_chk #(
    .RIDX_W (RIDX_W),
    .MIDX_W (MIDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rf_we_o    (rf_we_o),
    .rf_addr_o  (rf_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/rf_burst_seq_test.sv
`timescale 1ns/1ps
module rf_burst_seq_test;

    localparam int REG  = 8;
    localparam int MW   = 16;
    localparam int RW   = 3;
    localparam int MWW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dir = 1'b0;
    logic [31:0]   base = '0;
    logic [RW-1:0] rf_addr;
    logic          rf_we;
    logic [31:0]   rf_wdata;
    logic [31:0]   rf_rdata;
    logic [MWW-1:0] mem_addr;
    logic          mem_we;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          busy;
    logic          done;

    logic [31:0] rf_m  [REG];
    logic [31:0] mem_m [MW];
    logic [31:0] rf_s  [REG];
    logic [31:0] mem_s [MW];

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    rf_burst_seq #(
        .DATA_W    (32),
        .ADDR_W    (32),
        .REG_CNT   (REG),
        .MEM_WORDS (MW)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .dir_store_i (dir),
        .base_addr_i (base),
        .rf_addr_o   (rf_addr),
        .rf_we_o     (rf_we),
        .rf_wdata_o  (rf_wdata),
        .rf_rdata_i  (rf_rdata),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .busy_o      (busy),
        .done_o      (done)
    );

    // environment: combinational register read, one-cycle memory read
    assign rf_rdata = rf_m[rf_addr];
    always @(posedge clk) begin
        if (mem_we) mem_m[mem_addr] <= mem_wdata;
        if (rf_we)  rf_m[rf_addr]   <= rf_wdata;
        mem_rdata <= mem_m[mem_addr];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < REG; i++) rf_m[i] = 32'hA5A50000 ^ (n << 12) ^ (i * 32'h01000101);
        for (int w = 0; w < MW; w++) mem_m[w] = 32'h5A000000 ^ (n << 16) ^ (w * 32'h00010003);
        for (int i = 0; i < REG; i++) rf_s[i] = rf_m[i];
        for (int w = 0; w < MW; w++) mem_s[w] = mem_m[w];
    endtask

    // one burst; inj_mid: start with other direction mid-burst; inj_done: start on done cycle
    task automatic run_burst(input bit st, input logic [31:0] b, input bit inj_mid,
                             input bit inj_done);
        int cnt;
        int nwr;
        int bad0;
        int badw;
        int bw;
        int d;
        logic [31:0] e;
        bw = int'(b[MWW+1:2]);
        @(negedge clk);
        start = 1'b1; dir = st; base = b;
        @(negedge clk);
        start = 1'b0;
        dir = ~st;
        base = ~b;
        check(busy == 1'b1, "R6 busy after start", 32'(busy), 1);
        cnt = 0; nwr = 0; bad0 = 0; badw = 0;
        while (busy && cnt < 100) begin
            start = 1'b0;
            cnt++;
            if (rf_we && rf_addr == '0) bad0++;
            if (st && rf_we) badw++;
            if (!st && mem_we) badw++;
            if (rf_we && mem_we) badw++;
            if (st ? mem_we : rf_we) nwr++;
            if (inj_mid && cnt == 3) begin
                start = 1'b1;
                dir = ~st;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(cnt == (st ? REG - 1 : REG), "R5/R8 busy cycle count", 32'(cnt),
              32'(st ? REG - 1 : REG));
        check(nwr == REG - 1, "R5 transfer count", 32'(nwr), REG - 1);
        check(bad0 == 0, "R3 register 0 write", 32'(bad0), 0);
        check(badw == 0, "R9 wrong-side write", 32'(badw), 0);
        check(done == 1'b1 && busy == 1'b0, "R7 done after busy", {busy, done}, 32'b01);
        if (inj_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7 done single cycle", 32'(done), 0);
        if (inj_done) check(busy == 1'b0, "R8 start on done ignored", 32'(busy), 0);
        @(negedge clk);
        check(busy == 1'b0 && rf_we == 1'b0 && mem_we == 1'b0, "R8 no follow-on burst",
              {busy, rf_we, mem_we}, 0);
        for (int w = 0; w < MW; w++) begin
            d = (w - bw + MW) % MW;
            e = (st && d >= 1 && d <= REG - 1) ? rf_s[d] : mem_s[w];
            check(mem_m[w] === e, st ? "R1/R4 memory after store" : "R3/R9 memory after load",
                  mem_m[w], e);
        end
        for (int i = 0; i < REG; i++) begin
            e = (!st && i >= 1) ? mem_s[(bw + i) % MW] : rf_s[i];
            check(rf_m[i] === e, st ? "R9 registers after store" :
                  (i == 0 ? "R3 register 0 after load" : "R2/R4 registers after load"),
                  rf_m[i], e);
        end
    endtask

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && rf_we == 0 && mem_we == 0, "R10 in reset",
              {busy, done, rf_we, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && rf_we == 0 && mem_we == 0, "R10 after reset",
              {busy, done, rf_we, mem_we}, 0);
        for (int w = 0; w < MW; w++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] b;
                b = 32'(w << 2) | 32'(w % 4) | ((w % 2 == 1) ? 32'hFFF00000 : 32'h00000000);
                fill(w * 2 + s);
                run_burst(s[0], b, (w % 3 == 0), (w % 4 == 1));
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule